// File: doc/BRIEF.md
# Interval Timer with System and Per-Processor Channels

This block holds one system interval timer and one interval timer for each processor. Every timer has a count and a limit. On each cycle in which the shared tick enable is high, the count advances by one. When the count already equals a nonzero limit, that tick reloads the count to zero and sets a sticky interrupt flag instead. The system timer's flag drives the level-10 interrupt line. Each processor timer's flag drives that processor's level-14 line.

Software reaches the timers through a simple register bus. Reads return data one cycle after the request. Reading a timer's limit through its primary slot returns the flag and acknowledges it. A second slot returns the same word and leaves the flag set. A configuration register can switch any processor timer into a user-counter mode. In that mode the count runs freely, stops and starts under a per-processor run bit, and never interrupts.

The address is `{unit, slot}` with the slot in the two low bits. Units 0 to N_CPU-1 are the processor timers. Unit N_CPU is the system timer, which also holds the configuration register.

Top module: `interval_timer`

## Requirements
- R1: After reset every count, limit, flag, configuration bit and run bit is zero, `rdata_o` is zero and every interrupt output is low.
- R2: In timer mode, with a nonzero limit, each tick increments the count. A tick with count equal to limit sets the count to 0 and sets the flag; the flag appears on `irq_l10_o` (system) or `irq_l14_o[i]` (processor i) after that clock edge.
- R3: A read of slot 0 returns `{flag in bit 31, zeros, limit in bits COUNT_W-1:0}` on `rdata_o` one cycle later and clears the flag. If a limit match on a tick happens in the same cycle as this read, the flag stays set.
- R4: A read of slot 2 returns the same word as slot 0 and leaves the flag unchanged.
- R5: A write to slot 0 loads the limit from `wdata_i[COUNT_W-1:0]` and resets the count to 0. A write to slot 2 loads the limit and leaves the count unchanged.
- R6: With a limit of 0 the count runs on every tick and wraps from 2^COUNT_W-1 to 0, and the flag is never set.
- R7: The count (slot 1) is read-only, and writes to it have no effect.
- R8: Slot 3 of the system unit is the configuration register. Bit i = 1 puts processor timer i in user-counter mode, and writing 0 puts every processor timer in timer mode. It reads back in bits N_CPU-1:0.
- R9: In user-counter mode a processor timer counts ticks only while its run bit is 1. The run bit is bit 0 of slot 3 of its unit. The timer ignores its limit, wraps at 2^COUNT_W and never sets its flag.
- R10: Reads of an unused unit return 0, and writes to an unused unit have no effect.
- R11: A write to slot 0 takes priority over a tick in the same cycle: the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one step per high cycle |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | `{unit, slot[1:0]}` |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read, held otherwise |
| irq_l10_o | output | 1 | System timer interrupt (level 10) |
| irq_l14_o | output | N_CPU | Per-processor timer interrupts (level 14) |

## Verification
The count is visible only through slot 1. The interrupt lines show the flag on every cycle. A count or limit that is wrong therefore shows up in the cycle after the next count read, or as an interrupt edge that comes early, late or never. That interrupt edge is visible on the cycle right after the tick that should have matched. A stuck or wrongly cleared flag shows up at once on an interrupt line. Checking the interrupt lines on every cycle against an independent model catches a wrong flag state within one clock. A wrong count shows up at the latest at the next count read or the next expected limit match.

// File: rtl/itm_pkg.sv
`timescale 1ns/1ps
package itm_pkg;
  typedef enum logic [1:0] {
    SLOT_LIM      = 2'd0,
    SLOT_CNT      = 2'd1,
    SLOT_LIM_KEEP = 2'd2,
    SLOT_CTL      = 2'd3
  } slot_e;
endpackage

// File: rtl/itm_decode.sv
`timescale 1ns/1ps
module itm_decode
  import itm_pkg::*;
#(
  parameter int N_UNIT = 3,
  parameter int UNIT_W = 2,
  localparam int ADDR_W = UNIT_W + 2
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_UNIT-1:0] lim_wr_o,
  output logic [N_UNIT-1:0] keep_wr_o,
  output logic [N_UNIT-1:0] ctl_wr_o,
  output logic [N_UNIT-1:0] ack_o,
  output logic [UNIT_W-1:0] unit_o,
  output slot_e             slot_o,
  output logic              rd_o
);
  assign unit_o = addr_i[ADDR_W-1:2];
  assign slot_o = slot_e'(addr_i[1:0]);
  assign rd_o   = req_i & ~we_i;

  for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
    logic sel;
    assign sel          = req_i & (unit_o == UNIT_W'(u));
    assign lim_wr_o[u]  = sel & we_i & (slot_o == SLOT_LIM);
    assign keep_wr_o[u] = sel & we_i & (slot_o == SLOT_LIM_KEEP);
    assign ctl_wr_o[u]  = sel & we_i & (slot_o == SLOT_CTL);
    assign ack_o[u]     = sel & ~we_i & (slot_o == SLOT_LIM);
  end
endmodule

// File: rtl/itm_counter.sv
`timescale 1ns/1ps
module itm_counter #(
  parameter int CW = 22
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          user_i,
  input  logic          run_i,
  input  logic          lim_wr_i,
  input  logic          keep_wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          ack_i,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] limit_o,
  output logic          flag_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] count_q, limit_q;
  logic          flag_q, adv, hit;

  // user mode gates on run bit and never matches
  assign adv = tick_i & (~user_i | run_i);
  assign hit = ~user_i & (limit_q != '0) & (count_q == limit_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      limit_q <= '0;
    end else if (lim_wr_i) begin
      limit_q <= wdata_i;
      count_q <= '0;
    end else begin
      if (keep_wr_i) limit_q <= wdata_i;
      if (adv)       count_q <= hit ? '0 : count_q + ONE;
    end
  end

  // new match wins over acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (adv && hit) flag_q <= 1'b1;
    else if (ack_i)      flag_q <= 1'b0;
  end

  assign count_o = count_q;
  assign limit_o = limit_q;
  assign flag_o  = flag_q;

  a_r2_flag_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(tick_i && !user_i && count_o == limit_o && limit_o != '0));

  a_r2_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !user_i && !lim_wr_i && limit_o != '0 && count_o == limit_o) |=> (count_o == '0));

  a_r3_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !tick_i) |=> !flag_o);

  a_r4_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !ack_i) |=> flag_o);

  a_r6_zero_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_o == '0 && !flag_o) |=> !flag_o);

  a_r7_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !lim_wr_i) |=> $stable(count_o));

  a_r9_user_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_i && !flag_o) |=> !flag_o);

  a_r11_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_wr_i |=> (count_o == '0));
endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer
  import itm_pkg::*;
#(
  parameter int N_CPU   = 2,
  parameter int COUNT_W = 22,
  localparam int N_UNIT = N_CPU + 1,
  localparam int UNIT_W = $clog2(N_UNIT),
  localparam int ADDR_W = UNIT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_l10_o,
  output logic [N_CPU-1:0]  irq_l14_o
);
  localparam int SYS = N_CPU;

  logic [N_UNIT-1:0]  lim_wr, keep_wr, ctl_wr, ack, flg;
  logic [UNIT_W-1:0]  unit;
  slot_e              slot;
  logic               rd;
  logic [COUNT_W-1:0] cnt [N_UNIT];
  logic [COUNT_W-1:0] lim [N_UNIT];
  logic [N_CPU-1:0]   cfg_q, run_q;
  logic [31:0]        rd_word;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[31:COUNT_W];

  itm_decode #(.N_UNIT(N_UNIT), .UNIT_W(UNIT_W)) u_decode (
    .req_i, .we_i, .addr_i,
    .lim_wr_o(lim_wr), .keep_wr_o(keep_wr), .ctl_wr_o(ctl_wr), .ack_o(ack),
    .unit_o(unit), .slot_o(slot), .rd_o(rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      run_q <= '0;
    end else begin
      if (ctl_wr[SYS]) cfg_q <= wdata_i[N_CPU-1:0];
      for (int c = 0; c < N_CPU; c++)
        if (ctl_wr[c]) run_q[c] <= wdata_i[0];
    end
  end

  for (genvar u = 0; u < N_UNIT; u++) begin : g_tmr
    logic user, run;
    if (u < N_CPU) begin : g_cpu
      assign user = cfg_q[u];
      assign run  = run_q[u];
    end else begin : g_sys
      assign user = 1'b0;
      assign run  = 1'b1;
    end
    itm_counter #(.CW(COUNT_W)) u_cnt (
      .clk_i, .rst_ni, .tick_i,
      .user_i(user), .run_i(run),
      .lim_wr_i(lim_wr[u]), .keep_wr_i(keep_wr[u]),
      .wdata_i(wdata_i[COUNT_W-1:0]), .ack_i(ack[u]),
      .count_o(cnt[u]), .limit_o(lim[u]), .flag_o(flg[u])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int u = 0; u < N_UNIT; u++) begin
      if (unit == UNIT_W'(u)) begin
        unique case (slot)
          SLOT_LIM, SLOT_LIM_KEEP: begin
            rd_word[COUNT_W-1:0] = lim[u];
            rd_word[31]          = flg[u];
          end
          SLOT_CNT: rd_word[COUNT_W-1:0] = cnt[u];
          SLOT_CTL: begin
            if (u == SYS) rd_word[N_CPU-1:0] = cfg_q;
            else          rd_word[0]         = run_q[u];
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_word;
  end

  assign irq_l10_o = flg[SYS];
  assign irq_l14_o = flg[N_CPU-1:0];

  a_r10_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lim_wr | keep_wr | ctl_wr | ack));

  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr[SYS] |=> $stable(cfg_q));

  a_r1_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
  localparam int N  = 2;
  localparam int CW = 8;
  localparam int M  = (1 << CW) - 1;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        tick_i = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_l10_o;
  logic [N-1:0] irq_l14_o;

  int checks = 0, fails = 0;
  bit chk_en = 0, done = 0;

  interval_timer #(.N_CPU(N), .COUNT_W(CW)) u_interval_timer (.*);

  always #10 clk_i = ~clk_i;

  // reference model
  int m_cnt [3], m_lim [3];
  bit m_flag [3];
  int m_cfg, m_run [2];
  logic [31:0] m_rdata;
  int last_slot;

  function automatic logic [31:0] exp_read(int unit, int slot);
    logic [31:0] w = '0;
    if (unit > 2) return '0;
    case (slot)
      0, 2: begin w = 32'(m_lim[unit]); w[31] = m_flag[unit]; end
      1: w = 32'(m_cnt[unit]);
      default: w = (unit == 2) ? 32'(m_cfg) : 32'(m_run[unit]);
    endcase
    return w;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int u = 0; u < 3; u++) begin m_cnt[u] = 0; m_lim[u] = 0; m_flag[u] = 0; end
      m_cfg = 0; m_run[0] = 0; m_run[1] = 0; m_rdata = '0;
    end else begin
      int unit, slot, wd;
      bit rd;
      unit = int'(addr_i[3:2]); slot = int'(addr_i[1:0]); wd = int'(wdata_i & M);
      rd = req_i && !we_i;
      if (rd) begin m_rdata = exp_read(unit, slot); last_slot = (unit > 2) ? 9 : slot; end
      for (int u = 0; u < 3; u++) begin
        bit user, adv, hit, nf;
        user = (u < 2) && m_cfg[u];
        adv  = tick_i && (!user || (u < 2 && m_run[u] != 0));
        hit  = !user && m_lim[u] != 0 && m_cnt[u] == m_lim[u];
        nf = m_flag[u];
        if (adv && hit) nf = 1;
        else if (rd && unit == u && slot == 0) nf = 0;
        if (req_i && we_i && unit == u && slot == 0) begin
          m_lim[u] = wd; m_cnt[u] = 0;
        end else begin
          if (req_i && we_i && unit == u && slot == 2) m_lim[u] = wd;
          if (adv) m_cnt[u] = hit ? 0 : (m_cnt[u] + 1) & M;
        end
        m_flag[u] = nf;
      end
      if (req_i && we_i && slot == 3) begin
        if (unit < 2) m_run[unit] = wdata_i[0];
        else if (unit == 2) m_cfg = int'(wdata_i[1:0]);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string slot_tag(int s);
    case (s)
      0: return "R3 limit read";
      1: return "R2 count read";
      2: return "R4 alias read";
      3: return "R8 control read";
      default: return "R10 unused unit read";
    endcase
  endfunction

  always @(negedge clk_i) begin
    if (chk_en && rst_ni) begin
      check(slot_tag(last_slot), rdata_o, m_rdata);
      check("R2 irq_l10", 32'(irq_l10_o), 32'(m_flag[2]));
      check("R2 irq_l14", 32'(irq_l14_o), {30'b0, m_flag[1], m_flag[0]});
    end
  end

  task automatic drive(bit t, bit rq, bit w, int unit, int slot, int wd);
    @(negedge clk_i);
    tick_i = t; req_i = rq; we_i = w;
    addr_i = 4'((unit << 2) | slot); wdata_i = 32'(wd);
  endtask
  task automatic idle(); drive(0, 0, 0, 0, 0, 0); endtask
  task automatic wr(int unit, int slot, int wd);
    drive(0, 1, 1, unit, slot, wd); idle();
  endtask
  task automatic rd(int unit, int slot, output logic [31:0] d);
    drive(0, 1, 0, unit, slot, 0); idle(); d = rdata_o;
  endtask
  task automatic tk(int n);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 0, 0, 0);
    idle();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    last_slot = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk_en = 1;
    // R1 reset state
    rd(0, 0, d); check("R1 cpu0 limit", d, 0);
    rd(2, 1, d); check("R1 sys count", d, 0);
    rd(2, 3, d); check("R1 config", d, 0);
    check("R1 irqs", {29'b0, irq_l10_o, irq_l14_o}, 0);
    // R2 match and reload
    wr(0, 0, 3); tk(3);
    rd(0, 1, d); check("R2 count before match", d, 3);
    check("R2 no irq before match", 32'(irq_l14_o[0]), 0);
    tk(1);
    rd(0, 1, d); check("R2 count reload", d, 0);
    check("R2 irq after match", 32'(irq_l14_o[0]), 1);
    // R4 / R3
    rd(0, 2, d); check("R4 alias word", d, 32'h8000_0003);
    check("R4 flag kept", 32'(irq_l14_o[0]), 1);
    rd(0, 0, d); check("R3 limit word", d, 32'h8000_0003);
    check("R3 flag cleared", 32'(irq_l14_o[0]), 0);
    // R7
    wr(0, 1, 5); rd(0, 1, d); check("R7 count write ignored", d, 0);
    // R5
    tk(2);
    wr(0, 2, 9); rd(0, 1, d); check("R5 alias write keeps count", d, 2);
    rd(0, 2, d); check("R5 alias write loads limit", d, 9);
    wr(0, 0, 9); rd(0, 1, d); check("R5 limit write clears count", d, 0);
    // R6
    wr(2, 0, 0); tk(259);
    rd(2, 1, d); check("R6 zero limit wraps", d, 3);
    check("R6 no system irq", 32'(irq_l10_o), 0);
    // R8 / R9
    wr(2, 3, 2); rd(2, 3, d); check("R8 config readback", d, 2);
    wr(1, 3, 0); wr(1, 0, 2); tk(5);
    rd(1, 1, d); check("R9 stopped counter", d, 0);
    wr(1, 3, 1); tk(5);
    rd(1, 1, d); check("R9 user count ignores limit", d, 5);
    check("R9 no user irq", 32'(irq_l14_o[1]), 0);
    wr(2, 3, 0); rd(2, 3, d); check("R8 zero config", d, 0);
    // R11
    tk(2); drive(1, 1, 1, 0, 0, 4); idle();
    rd(0, 1, d); check("R11 write beats tick", d, 0);
    // R3 precedence: match with concurrent acknowledge
    wr(0, 0, 1); rd(0, 0, d); tk(1);
    drive(1, 1, 0, 0, 0, 0); idle();
    check("R3 read word before set", rdata_o, 32'h0000_0001);
    check("R3 match beats ack", 32'(irq_l14_o[0]), 1);
    // R10
    wr(3, 0, 7); rd(3, 0, d); check("R10 unused unit", d, 0);
    rd(0, 2, d); check("R10 no stray write", d & 32'hFF, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int wd;
      wd = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 8);
      drive(bit'($urandom % 2), ($urandom % 3) == 0, bit'($urandom % 2),
            int'($urandom % 4), int'($urandom % 4), wd);
    end
    idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule